// File: doc/BRIEF.md
# Graphics Event Interrupt Controller

This block turns two graphics-pipeline events into host interrupts. A token event arrives as a one-cycle pulse with a 16-bit value and a request flag. A finish event arrives as a bare pulse that marks the end of a frame. Each event kind has a pending flag. An interrupt output is raised when that flag and its enable bit are both set.

The host sees a small register port with word offsets. Offset 0 is the control word. It holds the two enable bits and two acknowledge bits, which clear a pending flag when written as 1. Offset 1 returns the last token value and cannot be written. Two waiting outputs show that an event has been accepted but its flag update has not yet been applied.

Each pipeline pulse is staged for one clock. The flag or value update lands on the next edge. The interrupt lines are registered one more clock after that.

Top module: `gfx_evt_irq`

## Requirements
- R1: After reset, the control word and the token register read 0, and both interrupt outputs, the cause vector and both waiting outputs are 0.
- R2: A write to offset 0 stores bit 0 (token enable) and bit 1 (finish enable). A read of offset 0 returns those two bits in place, with bits 15..2 always 0, so the acknowledge bits 2 and 3 read back as 0.
- R3: A write to offset 0 with bit 2 set clears the pending token flag, and one with bit 3 set clears the pending finish flag, when no event update is applied in that cycle.
- R4: `irq_token` equals the AND of the pending token flag and the token enable, as they stood one clock earlier.
- R5: `irq_finish` equals the AND of the pending finish flag and the finish enable, as they stood one clock earlier.
- R6: `irq_cause` carries `irq_token` at bit 9 (value 0x200) and `irq_finish` at bit 10 (value 0x400), with every other bit 0.
- R7: A token pulse loads its value into the token register two edges after the pulse, whatever the request flag. The pending token flag is set at that same edge only when the request flag was 1.
- R8: A finish pulse always sets the pending finish flag, two edges after the pulse.
- R9: Host writes to offset 1 leave the token register unchanged.
- R10: Reads of any offset other than 0 and 1 return 0.
- R11: When an acknowledge write lands in the same cycle as the flag update of an event of the same kind, the flag stays set.
- R12: `tok_waiting` and `fin_waiting` are high for exactly the one cycle between a pulse's capture and the application of its update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_tok_pulse | input | 1 | Token event strobe |
| evt_tok_value | input | 16 | Token value carried by the strobe |
| evt_tok_req | input | 1 | Token strobe asks for an interrupt |
| evt_fin_pulse | input | 1 | Finish event strobe |
| host_addr | input | 4 | Word offset of the host access |
| host_wr_en | input | 1 | Host write strobe |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Combinational read data for `host_addr` |
| irq_token | output | 1 | Token interrupt level |
| irq_finish | output | 1 | Finish interrupt level |
| irq_cause | output | 16 | Combined interrupt cause vector |
| tok_waiting | output | 1 | Token update in flight |
| fin_waiting | output | 1 | Finish update in flight |

## Verification
The token path is tried with the request flag set and with it clear. Both cases must load the value, but only the first may raise the interrupt, which separates the value path from the flag path. Enables are toggled with flags both pending and idle, so gating can be told apart from flag state. An acknowledge is issued on its own and again in the same cycle as an event update, which checks both the clearing and the event-wins priority. Writes to the read-only offset and reads of unmapped offsets confirm that neither changes visible state.

// File: rtl/gfx_evt_pkg.sv
// Shared constants and types for the graphics event interrupt controller.
// Assumes 16-bit host data; offsets are word offsets.
package gfx_evt_pkg;
    localparam int CTRL_OFS      = 0;
    localparam int TOKEN_OFS     = 1;
    localparam int TOK_EN_BIT    = 0;
    localparam int FIN_EN_BIT    = 1;
    localparam int TOK_ACK_BIT   = 2;
    localparam int FIN_ACK_BIT   = 3;
    localparam int CAUSE_TOK_BIT = 9;
    localparam int CAUSE_FIN_BIT = 10;

    typedef struct packed {
        logic fin_en;
        logic tok_en;
    } evt_ctrl_t;
endpackage

// File: rtl/gfx_evt_pending.sv
// One event kind: stages the pulse for a cycle, then updates the pending flag.
// Assumes the ack input is a single-cycle strobe from the host decoder.
module gfx_evt_pending (
    input  logic clk,
    input  logic rst_n,
    input  logic evt_pulse,
    input  logic evt_req,
    input  logic ack,
    output logic pending,
    output logic waiting
);
    logic stage_q;
    logic stage_req_q;
    logic apply_set;

    assign apply_set = stage_q && stage_req_q;
    assign waiting   = stage_q;

    // Capture the incoming pulse and its request flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q     <= 1'b0;
            stage_req_q <= 1'b0;
        end else begin
            stage_q     <= evt_pulse;
            stage_req_q <= evt_pulse && evt_req;
        end
    end

    // Pending flag: the staged event takes priority over an acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n)         pending <= 1'b0;
        else if (apply_set) pending <= 1'b1;
        else if (ack)       pending <= 1'b0;
    end

    assert_event_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (apply_set && ack) |=> pending);
    assert_ack_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !apply_set) |=> !pending);
    assert_wait_one_cycle_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (waiting && !evt_pulse) |=> !waiting);
endmodule

// File: rtl/gfx_evt_token_reg.sv
// Token value register: stages the pulse value, then loads it on the next edge.
// Assumes the request flag does not gate the value path.
module gfx_evt_token_reg #(
    parameter int VAL_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             evt_pulse,
    input  logic [VAL_W-1:0] evt_value,
    output logic [VAL_W-1:0] token_q
);
    logic             stage_v;
    logic [VAL_W-1:0] stage_val;

    // Hold the value that came with the pulse for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_v   <= 1'b0;
            stage_val <= '0;
        end else begin
            stage_v   <= evt_pulse;
            if (evt_pulse) stage_val <= evt_value;
        end
    end

    // Load the staged value into the visible token register.
    always_ff @(posedge clk) begin
        if (!rst_n)       token_q <= '0;
        else if (stage_v) token_q <= stage_val;
    end

    assert_token_only_from_event_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !stage_v |=> $stable(token_q));
endmodule

// File: rtl/gfx_evt_hostregs.sv
// Host register port: control word with enables and acknowledge strobes,
// read-only token word, zero for unmapped offsets.
// Assumes single-cycle write strobes and combinational reads.
module gfx_evt_hostregs
    import gfx_evt_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic              host_wr_en,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic [DATA_W-1:0] token_q,
    output evt_ctrl_t         ctrl,
    output logic              tok_ack,
    output logic              fin_ack,
    output logic [DATA_W-1:0] host_rdata
);
    logic sel_ctrl;
    logic sel_token;
    logic ctrl_wr;

    assign sel_ctrl  = (host_addr == ADDR_W'(CTRL_OFS));
    assign sel_token = (host_addr == ADDR_W'(TOKEN_OFS));
    assign ctrl_wr   = host_wr_en && sel_ctrl;
    assign tok_ack   = ctrl_wr && host_wdata[TOK_ACK_BIT];
    assign fin_ack   = ctrl_wr && host_wdata[FIN_ACK_BIT];

    // Store the enable bits on every control write; ack bits are not kept.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl <= '0;
        end else if (ctrl_wr) begin
            ctrl.tok_en <= host_wdata[TOK_EN_BIT];
            ctrl.fin_en <= host_wdata[FIN_EN_BIT];
        end
    end

    // Read mux by offset.
    always_comb begin
        host_rdata = '0;
        if (sel_ctrl) begin
            host_rdata[TOK_EN_BIT] = ctrl.tok_en;
            host_rdata[FIN_EN_BIT] = ctrl.fin_en;
        end else if (sel_token) begin
            host_rdata = token_q;
        end
    end

    assert_enable_stored_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr |=> (ctrl.tok_en == $past(host_wdata[TOK_EN_BIT])) &&
                    (ctrl.fin_en == $past(host_wdata[FIN_EN_BIT])));
    assert_ctrl_upper_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        sel_ctrl |-> (host_rdata[DATA_W-1:2] == '0));
endmodule

// File: rtl/gfx_evt_irq_out.sv
// Registered interrupt lines and the combined cause vector.
// Assumes pending flags and enables come from separate registers.
module gfx_evt_irq_out
    import gfx_evt_pkg::*;
#(
    parameter int CAUSE_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tok_pend,
    input  logic               fin_pend,
    input  evt_ctrl_t          ctrl,
    output logic               irq_token,
    output logic               irq_finish,
    output logic [CAUSE_W-1:0] irq_cause
);
    // Register each line as flag AND enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_token  <= 1'b0;
            irq_finish <= 1'b0;
        end else begin
            irq_token  <= tok_pend && ctrl.tok_en;
            irq_finish <= fin_pend && ctrl.fin_en;
        end
    end

    // Place each line at its cause bit.
    always_comb begin
        irq_cause                = '0;
        irq_cause[CAUSE_TOK_BIT] = irq_token;
        irq_cause[CAUSE_FIN_BIT] = irq_finish;
    end

    assert_irq_token_R4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> irq_token == $past(tok_pend && ctrl.tok_en));
    assert_irq_finish_R5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> irq_finish == $past(fin_pend && ctrl.fin_en));
    assert_cause_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(irq_cause) == (32'(irq_token) + 32'(irq_finish)));
endmodule

// File: rtl/gfx_evt_irq.sv
// Top: graphics token/finish interrupt controller.
// Assumes event pulses last one cycle and host strobes are synchronous.
module gfx_evt_irq
    import gfx_evt_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int ADDR_W  = 4,
    parameter int CAUSE_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               evt_tok_pulse,
    input  logic [DATA_W-1:0]  evt_tok_value,
    input  logic               evt_tok_req,
    input  logic               evt_fin_pulse,
    input  logic [ADDR_W-1:0]  host_addr,
    input  logic               host_wr_en,
    input  logic [DATA_W-1:0]  host_wdata,
    output logic [DATA_W-1:0]  host_rdata,
    output logic               irq_token,
    output logic               irq_finish,
    output logic [CAUSE_W-1:0] irq_cause,
    output logic               tok_waiting,
    output logic               fin_waiting
);
    evt_ctrl_t         ctrl;
    logic              tok_ack;
    logic              fin_ack;
    logic              tok_pend;
    logic              fin_pend;
    logic [DATA_W-1:0] token_q;

    gfx_evt_hostregs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr_en(host_wr_en),
        .host_wdata(host_wdata), .token_q(token_q), .ctrl(ctrl),
        .tok_ack(tok_ack), .fin_ack(fin_ack), .host_rdata(host_rdata)
    );

    gfx_evt_token_reg #(.VAL_W(DATA_W)) u_token (
        .clk(clk), .rst_n(rst_n), .evt_pulse(evt_tok_pulse),
        .evt_value(evt_tok_value), .token_q(token_q)
    );

    gfx_evt_pending u_tok_pend (
        .clk(clk), .rst_n(rst_n), .evt_pulse(evt_tok_pulse), .evt_req(evt_tok_req),
        .ack(tok_ack), .pending(tok_pend), .waiting(tok_waiting)
    );

    gfx_evt_pending u_fin_pend (
        .clk(clk), .rst_n(rst_n), .evt_pulse(evt_fin_pulse), .evt_req(1'b1),
        .ack(fin_ack), .pending(fin_pend), .waiting(fin_waiting)
    );

    gfx_evt_irq_out #(.CAUSE_W(CAUSE_W)) u_irq (
        .clk(clk), .rst_n(rst_n), .tok_pend(tok_pend), .fin_pend(fin_pend),
        .ctrl(ctrl), .irq_token(irq_token), .irq_finish(irq_finish),
        .irq_cause(irq_cause)
    );

    assert_fin_event_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fin_waiting |=> fin_pend);
endmodule

// File: tb/gfx_evt_irq_bench.sv
`timescale 1ns/1ps
module gfx_evt_irq_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        evt_tok_pulse;
    logic [15:0] evt_tok_value;
    logic        evt_tok_req;
    logic        evt_fin_pulse;
    logic [3:0]  host_addr;
    logic        host_wr_en;
    logic [15:0] host_wdata;
    logic [15:0] host_rdata;
    logic        irq_token;
    logic        irq_finish;
    logic [15:0] irq_cause;
    logic        tok_waiting;
    logic        fin_waiting;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2 clk = ~clk;

    gfx_evt_irq u_gfx_evt_irq (
        .clk(clk), .rst_n(rst_n), .evt_tok_pulse(evt_tok_pulse),
        .evt_tok_value(evt_tok_value), .evt_tok_req(evt_tok_req),
        .evt_fin_pulse(evt_fin_pulse), .host_addr(host_addr),
        .host_wr_en(host_wr_en), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .irq_token(irq_token), .irq_finish(irq_finish), .irq_cause(irq_cause),
        .tok_waiting(tok_waiting), .fin_waiting(fin_waiting)
    );

    task automatic check(input logic [15:0] act, input logic [15:0] exp, input string tag);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%04h expected 0x%04h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] d);
        host_addr = a;
        #1 d = host_rdata;
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        host_addr = a; host_wdata = d; host_wr_en = 1'b1;
        @(negedge clk);
        host_wr_en = 1'b0; host_wdata = '0; host_addr = '0;
    endtask

    task automatic tok_pulse(input logic [15:0] v, input logic req);
        evt_tok_pulse = 1'b1; evt_tok_value = v; evt_tok_req = req;
        @(negedge clk);
        evt_tok_pulse = 1'b0; evt_tok_req = 1'b0; evt_tok_value = '0;
    endtask

    task automatic fin_pulse();
        evt_fin_pulse = 1'b1;
        @(negedge clk);
        evt_fin_pulse = 1'b0;
    endtask

    task automatic t_reset();
        logic [15:0] d;
        rd(4'd0, d); check(d, 16'h0000, "R1 ctrl after reset");
        rd(4'd1, d); check(d, 16'h0000, "R1 token after reset");
        check({irq_token, irq_finish, tok_waiting, fin_waiting}, 16'h0, "R1 outputs after reset");
        check(irq_cause, 16'h0000, "R1 cause after reset");
    endtask

    task automatic t_ctrl_rw();
        logic [15:0] d;
        wr(4'd0, 16'hFFF2);
        rd(4'd0, d); check(d, 16'h0002, "R2 only finish enable kept, acks read 0");
        wr(4'd0, 16'h0001);
        rd(4'd0, d); check(d, 16'h0001, "R2 token enable kept");
        wr(4'd0, 16'h0000);
    endtask

    task automatic t_token_noreq();
        logic [15:0] d;
        wr(4'd0, 16'h0001);
        tok_pulse(16'hA5C3, 1'b0);
        check(16'(tok_waiting), 16'h1, "R12 token waiting after pulse");
        @(negedge clk);
        check(16'(tok_waiting), 16'h0, "R12 token waiting clears");
        rd(4'd1, d); check(d, 16'hA5C3, "R7 value loaded without request");
        @(negedge clk);
        check(16'(irq_token), 16'h0, "R7 no interrupt without request");
    endtask

    task automatic t_token_req();
        logic [15:0] d;
        tok_pulse(16'h1234, 1'b1);
        @(negedge clk);
        rd(4'd1, d); check(d, 16'h1234, "R7 value loaded with request");
        check(16'(irq_token), 16'h0, "R4 irq one clock after flag");
        @(negedge clk);
        check(16'(irq_token), 16'h1, "R4 token interrupt raised");
        check(irq_cause, 16'h0200, "R6 token cause");
        wr(4'd0, 16'h0000);
        @(negedge clk);
        check(16'(irq_token), 16'h0, "R4 disable masks token interrupt");
        wr(4'd0, 16'h0001);
        @(negedge clk);
        check(16'(irq_token), 16'h1, "R4 flag held while masked");
    endtask

    task automatic t_ack();
        wr(4'd0, 16'h0005);
        check(16'(irq_token), 16'h1, "R3 irq lags ack by a clock");
        @(negedge clk);
        check(16'(irq_token), 16'h0, "R3 token ack clears flag");
    endtask

    task automatic t_finish();
        wr(4'd0, 16'h0002);
        fin_pulse();
        check(16'(fin_waiting), 16'h1, "R12 finish waiting after pulse");
        @(negedge clk);
        check(16'(fin_waiting), 16'h0, "R12 finish waiting clears");
        @(negedge clk);
        check(16'(irq_finish), 16'h1, "R5 finish interrupt raised");
        check(irq_cause, 16'h0400, "R6 finish cause");
        wr(4'd0, 16'h0003);
        @(negedge clk);
        tok_pulse(16'h0042, 1'b1);
        @(negedge clk);
        @(negedge clk);
        check(irq_cause, 16'h0600, "R6 both causes");
        wr(4'd0, 16'h000F);
        @(negedge clk);
        check(irq_cause, 16'h0000, "R3 both acks clear");
        check(16'(irq_finish), 16'h0, "R8 R3 finish cleared");
    endtask

    task automatic t_collision();
        tok_pulse(16'h7777, 1'b1);
        fin_pulse();
        wr(4'd0, 16'h000F);
        @(negedge clk);
        check(16'(irq_token), 16'h0, "R11 token ack alone clears");
        tok_pulse(16'h0BEE, 1'b1);
        host_addr = 4'd0; host_wdata = 16'h0007; host_wr_en = 1'b1;
        @(negedge clk);
        host_wr_en = 1'b0;
        @(negedge clk);
        check(16'(irq_token), 16'h1, "R11 token event beats ack");
        evt_fin_pulse = 1'b1;
        @(negedge clk);
        evt_fin_pulse = 1'b0;
        host_addr = 4'd0; host_wdata = 16'h000B; host_wr_en = 1'b1;
        @(negedge clk);
        host_wr_en = 1'b0;
        @(negedge clk);
        check(16'(irq_finish), 16'h1, "R11 finish event beats ack");
        wr(4'd0, 16'h000F);
        @(negedge clk);
    endtask

    task automatic t_readonly_unmapped();
        logic [15:0] d;
        wr(4'd1, 16'hDEAD);
        @(negedge clk);
        rd(4'd1, d); check(d, 16'h0BEE, "R9 token write ignored");
        rd(4'd0, d); check(d, 16'h0003, "R9 ctrl untouched by token write");
        rd(4'd2, d); check(d, 16'h0000, "R10 offset 2 reads 0");
        rd(4'd15, d); check(d, 16'h0000, "R10 offset 15 reads 0");
    endtask

    initial begin
        rst_n = 1'b0; evt_tok_pulse = 1'b0; evt_tok_value = '0; evt_tok_req = 1'b0;
        evt_fin_pulse = 1'b0; host_addr = '0; host_wr_en = 1'b0; host_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_ctrl_rw();
        t_token_noreq();
        t_token_req();
        t_ack();
        t_finish();
        t_collision();
        t_readonly_unmapped();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule